// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank SDRAM from power-up to normal operation. After reset it raises the clock enable and keeps the command bus idle for at least 200 µs. It then issues the bring-up commands in a fixed order: one precharge of all banks, eight auto-refresh commands, and one mode-register load. Once the mode-load settling time has passed, it reports that the device is ready. The idle time and every gap between commands are counted in clock cycles. Those counts come from static configuration inputs: the clock rate in kHz and the precharge, refresh-cycle and mode-load delays.

After bring-up, the block runs a periodic timer that pulses a refresh request every 15.6 µs. The interval in cycles is derived from the configured clock rate. A controller outside this block arbitrates that request against its own traffic. A synchronous reset at any time abandons the sequence and restarts it from the idle pause.

Top module: `sdr_init_seq`

## Requirements
- R1: While reset is high, the block drives NOP, holds the clock enable low and keeps ready and the refresh request low. A reset in mid-sequence or after ready restarts the whole sequence from the pause.
- R2: After reset is released, the clock enable is high on every cycle. The command bus carries NOP for exactly P = ceil(clk_khz / 5) cycles (at least 1), counted from the first cycle with the clock enable high. The next cycle carries a precharge-all with address bit 10 at 1, all other address bits at 0, and bank 0.
- R3: Exactly eight auto-refresh commands follow. The first comes tRP' cycles after the precharge, and each later one comes tRC' cycles after the one before it.
- R4: A mode-load command comes tRC' cycles after the eighth refresh. Its address carries the CAS latency in bits 6:4 and zero in every other bit, which selects burst length 1 with sequential order. Its bank is 0.
- R5: The ready output rises exactly tMRD' cycles after the mode-load command and stays high until the next reset.
- R6: Command encodings, given as {cs_n, ras_n, cas_n, we_n}: NOP 0111, precharge 0010, auto-refresh 0001, mode load 0000.
- R7: Every cycle that does not carry one of the commands listed in R2 to R4 carries NOP. This includes every wait cycle and every cycle of normal operation.
- R8: In normal operation the refresh request is a one-cycle pulse with period R = max(1, floor(156 × clk_khz / 10000)) cycles. The first pulse falls in the R-th cycle with ready high, and the request never pulses while ready is low.
- R9: A configured delay of zero counts as one cycle: tX' = max(tX, 1) for tRP, tRC and tMRD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cas_lat | input | 3 | CAS latency written into the mode register |
| cfg_trp | input | TW | Precharge-to-command delay in cycles |
| cfg_trc | input | TW | Refresh-to-command delay in cycles |
| cfg_tmrd | input | TW | Mode-load-to-ready delay in cycles |
| cfg_clk_khz | input | KHZ_W | Clock frequency in kHz |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W | SDRAM address bus |
| sdr_ba | output | BA_W | SDRAM bank select |
| init_done | output | 1 | High once normal operation is reached |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
A wrong count in the shared wait timer shifts the next command on the bus by a whole cycle or more. The bench therefore compares the command pins against a cycle-exact schedule and reports the first cycle where they differ. A wrong refresh counter shows as a ninth refresh or an early mode load, within one refresh gap. A wrong mode word or precharge address shows on the address pins in the very cycle of that command. A wrong refresh timer shows at the first request pulse after ready.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_GAP_RP,
    ST_REF,
    ST_GAP_RC,
    ST_MRS,
    ST_GAP_MRD,
    ST_RUN
  } seq_state_e;

  // 200 us at khz kHz = khz/5 cycles, rounded up, never below one
  function automatic logic [31:0] pause_len(input logic [31:0] khz);
    logic [31:0] p;
    p = (khz + 32'd4) / 32'd5;
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

  // 15.6 us interval in cycles, never below one
  function automatic logic [31:0] refi_len(input logic [31:0] khz);
    logic [31:0] r;
    r = (khz * 32'd156) / 32'd10000;
    return (r == 32'd0) ? 32'd1 : r;
  endfunction

  // a zero delay is treated as a single cycle
  function automatic logic [31:0] gap_len(input logic [31:0] t);
    return (t == 32'd0) ? 32'd1 : t;
  endfunction

  // burst length 1, sequential, CAS latency in bits 6:4
  function automatic logic [31:0] mode_word(input logic [2:0] cl);
    return {25'd0, cl, 4'b0000};
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == '0);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= period - 1'b1;
    else if (wrap)
      cnt_q <= period - 1'b1;
    else
      cnt_q <= cnt_q - 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && period > 1) |=> !tick); // R8

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  sdr_cmd_e          cmd,
  input  logic [2:0]        cas_lat,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int A10 = 10;

  always_comb begin
    cs_n                 = 1'b0;
    {ras_n, cas_n, we_n} = 3'b111;
    addr                 = '0;
    ba                   = '0;
    unique case (cmd)
      CMD_PRE: begin
        {ras_n, cas_n, we_n} = 3'b010;
        addr                 = ADDR_W'(32'd1 << A10);
      end
      CMD_REF: {ras_n, cas_n, we_n} = 3'b001;
      CMD_MRS: begin
        {ras_n, cas_n, we_n} = 3'b000;
        addr                 = ADDR_W'(mode_word(cas_lat));
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int TW      = 5,
  parameter int KHZ_W   = 20,
  parameter int NUM_REF = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_trc,
  input  logic [TW-1:0]     cfg_tmrd,
  input  logic [KHZ_W-1:0]  cfg_clk_khz,
  output logic              sdr_cke,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic [BA_W-1:0]   sdr_ba,
  output logic              init_done,
  output logic              refresh_req
);
  localparam int GW   = (KHZ_W > TW) ? KHZ_W : TW;
  localparam int RC_W = $clog2(NUM_REF + 1);

  seq_state_e       st_q, st_d;
  logic [RC_W-1:0]  ref_cnt_q;
  logic             ref_inc;
  logic             cke_q;
  logic             tmr_load, tmr_expired;
  logic [GW-1:0]    tmr_val;
  logic [31:0]      gap_rp, gap_rc, gap_mrd;
  logic [KHZ_W-1:0] refi_period;
  sdr_cmd_e         cmd;

  // named internal events
  logic cmd_pre, cmd_ref, cmd_mrs, last_ref, refs_all_done;

  assign gap_rp        = gap_len(32'(cfg_trp));
  assign gap_rc        = gap_len(32'(cfg_trc));
  assign gap_mrd       = gap_len(32'(cfg_tmrd));
  assign refi_period   = KHZ_W'(refi_len(32'(cfg_clk_khz)));
  assign last_ref      = (ref_cnt_q == RC_W'(NUM_REF - 1));
  assign refs_all_done = (ref_cnt_q == RC_W'(NUM_REF));

  always_comb begin
    st_d     = st_q;
    tmr_load = rst;
    tmr_val  = GW'(pause_len(32'(cfg_clk_khz)));
    ref_inc  = 1'b0;
    if (!rst) begin
      unique case (st_q)
        ST_PAUSE: if (tmr_expired) st_d = ST_PRE;
        ST_PRE: begin
          if (gap_rp <= 32'd1) st_d = ST_REF;
          else begin
            st_d     = ST_GAP_RP;
            tmr_load = 1'b1;
            tmr_val  = GW'(gap_rp - 32'd2);
          end
        end
        ST_GAP_RP: if (tmr_expired) st_d = ST_REF;
        ST_REF: begin
          ref_inc = 1'b1;
          if (gap_rc <= 32'd1) st_d = last_ref ? ST_MRS : ST_REF;
          else begin
            st_d     = ST_GAP_RC;
            tmr_load = 1'b1;
            tmr_val  = GW'(gap_rc - 32'd2);
          end
        end
        ST_GAP_RC: if (tmr_expired) st_d = refs_all_done ? ST_MRS : ST_REF;
        ST_MRS: begin
          if (gap_mrd <= 32'd1) st_d = ST_RUN;
          else begin
            st_d     = ST_GAP_MRD;
            tmr_load = 1'b1;
            tmr_val  = GW'(gap_mrd - 32'd2);
          end
        end
        ST_GAP_MRD: if (tmr_expired) st_d = ST_RUN;
        ST_RUN: st_d = ST_RUN;
        default: st_d = ST_PAUSE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_PAUSE;
      ref_cnt_q <= '0;
      cke_q     <= 1'b0;
    end else begin
      st_q  <= st_d;
      cke_q <= 1'b1;
      if (ref_inc) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  assign cmd_pre   = (cmd == CMD_PRE);
  assign cmd_ref   = (cmd == CMD_REF);
  assign cmd_mrs   = (cmd == CMD_MRS);
  assign init_done = (st_q == ST_RUN);
  assign sdr_cke   = cke_q;

  sdr_gap_timer #(.W(GW)) u_gap (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdr_refi_timer #(.W(KHZ_W)) u_refi (
    .clk    (clk),
    .rst    (rst),
    .run    (init_done),
    .period (refi_period),
    .tick   (refresh_req)
  );

  sdr_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .cmd     (cmd),
    .cas_lat (cfg_cas_lat),
    .cs_n    (sdr_cs_n),
    .ras_n   (sdr_ras_n),
    .cas_n   (sdr_cas_n),
    .we_n    (sdr_we_n),
    .addr    (sdr_addr),
    .ba      (sdr_ba)
  );

  AST_CKE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sdr_cke); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    cmd_pre |-> (sdr_addr[10] && !sdr_ras_n && sdr_cas_n && !sdr_we_n)); // R2
  AST_MRS_AFTER_ALL_REFS: assert property (@(posedge clk) disable iff (rst)
    cmd_mrs |-> refs_all_done); // R3
  AST_NO_EXTRA_REF: assert property (@(posedge clk) disable iff (rst)
    cmd_ref |-> !refs_all_done); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R5
  AST_REQ_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> init_done); // R8

endmodule

// File: tb/tb_sdr_init_seq.sv
module tb_sdr_init_seq;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int TW     = 5;
  localparam int KHZ_W  = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        cl = 3'd3;
  logic [TW-1:0]     trp = 5'd3, trc = 5'd9, tmrd = 5'd3;
  logic [KHZ_W-1:0]  khz = 20'd125000;
  logic              cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;

  int checks = 0;
  int errors = 0;
  int tcyc   = 0;

  always #4 clk = ~clk;

  sdr_init_seq dut (
    .clk(clk), .rst(rst), .cfg_cas_lat(cl), .cfg_trp(trp), .cfg_trc(trc),
    .cfg_tmrd(tmrd), .cfg_clk_khz(khz), .sdr_cke(cke), .sdr_cs_n(cs_n),
    .sdr_ras_n(ras_n), .sdr_cas_n(cas_n), .sdr_we_n(we_n), .sdr_addr(addr),
    .sdr_ba(ba), .init_done(init_done), .refresh_req(refresh_req)
  );

  always @(posedge clk) begin
    tcyc++;
    if (tcyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", tcyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // 0 NOP, 1 precharge, 2 refresh, 3 mode load, 9 unknown (R6)
  function automatic int obs_cmd();
    case ({cs_n, ras_n, cas_n, we_n})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 9;
    endcase
  endfunction

  function automatic string tag(int e);
    case (e)
      1: return "R6,R2";
      2: return "R6,R3";
      3: return "R6,R4";
      default: return "R6,R7";
    endcase
  endfunction

  function automatic int b_pause(int k);
    int p = (k * 200 + 999) / 1000;
    return (p < 1) ? 1 : p;
  endfunction

  function automatic int b_refi(int k);
    longint r = (longint'(k) * 156) / 10000;
    return (r < 1) ? 1 : int'(r);
  endfunction

  function automatic int b_gap(int t);
    return (t < 1) ? 1 : t;
  endfunction

  task automatic check_reset_state(input string req);
    chk(obs_cmd() == 0, req, "command in reset", obs_cmd(), 0);
    chk(cke == 1'b0, req, "cke in reset", cke, 0);
    chk(init_done == 1'b0, req, "ready in reset", init_done, 0);
    chk(refresh_req == 1'b0, req, "request in reset", refresh_req, 0);
  endtask

  task automatic run_case(input int k, input int c, input int rp, input int rc,
                          input int mrd, input int abort_at);
    int P, grp, grc, gmrd, R, pre_c, ref0, mrs_c, done_c, end_c;
    int nref, first_ref, e, o, errs0;
    bit bad, exp_req;
    @(negedge clk);
    rst  = 1'b1;
    khz  = KHZ_W'(k);
    cl   = 3'(c);
    trp  = TW'(rp);
    trc  = TW'(rc);
    tmrd = TW'(mrd);
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;
    P = b_pause(k); grp = b_gap(rp); grc = b_gap(rc); gmrd = b_gap(mrd);
    R = b_refi(k);
    pre_c  = P + 1;
    ref0   = pre_c + grp;
    mrs_c  = ref0 + 8 * grc;
    done_c = mrs_c + gmrd;
    end_c  = done_c + 3 * R;
    nref = 0; first_ref = 0; bad = 1'b0;
    for (int cyc = 1; cyc <= end_c && !bad; cyc++) begin
      @(negedge clk);
      errs0 = errors;
      if (cyc == pre_c) e = 1;
      else if (cyc >= ref0 && cyc < mrs_c && ((cyc - ref0) % grc) == 0) e = 2;
      else if (cyc == mrs_c) e = 3;
      else e = 0;
      o = obs_cmd();
      chk(o == e, tag(e), "command", o, e);
      if (e == 1) chk(addr == 13'd1024 && ba == '0, "R2", "precharge address", addr, 1024);
      if (e == 3) chk(addr == ADDR_W'(c << 4) && ba == '0, "R4", "mode word", addr, c << 4);
      if (o == 2) begin
        nref++;
        if (first_ref == 0) first_ref = cyc;
      end
      chk(cke == 1'b1, "R2", "cke high", cke, 1);
      chk(init_done == (cyc >= done_c), "R5", "ready", init_done, cyc >= done_c);
      exp_req = (cyc >= done_c + R - 1) && (((cyc - done_c - (R - 1)) % R) == 0);
      chk(refresh_req == exp_req, "R8", "refresh request", refresh_req, exp_req);
      if (abort_at != 0 && cyc == abort_at) begin
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("R1");
        return;
      end
      if (errors != errs0) bad = 1'b1;
    end
    chk(nref == 8, "R3", "refresh count", nref, 8);
    chk(first_ref == ref0, "R9", "first refresh cycle", first_ref, ref0);
  endtask

  initial begin
    int k, g1;
    void'($urandom(32'h5D1E));
    // shortest pause, all delays zero, one-cycle refresh interval (R9, R8)
    run_case(5, 7, 0, 0, 0, 0);
    // 125 MHz with typical delays (R2..R5, R8)
    run_case(125000, 3, 3, 9, 3, 0);
    // abort in the middle of the refresh run, then full restart (R1)
    g1 = b_pause(2000) + 1 + 2 + 2 * 6 + 1;
    run_case(2000, 2, 2, 6, 3, g1);
    run_case(2000, 2, 2, 6, 3, 0);
    // abort after ready (R1)
    g1 = b_pause(3000) + 1 + 1 + 8 * 4 + 2 + 5;
    run_case(3000, 2, 1, 4, 2, g1);
    run_case(3000, 2, 1, 4, 2, 0);
    // random configurations
    for (int i = 0; i < 6; i++) begin
      k = int'($urandom_range(20000, 1000));
      run_case(k, int'($urandom_range(7, 0)), int'($urandom_range(10, 0)),
               int'($urandom_range(15, 0)), int'($urandom_range(6, 0)), 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule